// File: doc/BRIEF.md
# Shifter Operand Generation Unit

This unit forms the second operand of a data-processing datapath. It picks a 32-bit source value, either a register value or an immediate. It then passes the value through untouched, or it applies one of five shift or rotate kinds. It also produces the shifter carry-out that a later flag stage can consume. The shift distance comes from a small immediate field or from the low byte of a second register value. The incoming carry flag feeds both the pass-through carry and the one-bit rotate through carry.

The operand path is purely combinational. A build-time parameter can place a single output register after it, which adds one cycle of latency and resets to zero. Instruction decode, the ALU, flag writeback and register-file access are left to the surrounding datapath.

The data width must be a power of two, and the register amount width must not exceed it.

Top module: `opgen_shifter`

## Requirements
- R1: Kind code 0 (pass) delivers the selected source value unchanged and copies `carry_i` to `carry_o`. The unused codes 6 and 7 behave exactly like code 0.
- R2: When `src_is_imm_i` is 1 the source value is `val_imm_i`, otherwise it is `val_reg_i`, for every kind.
- R3: Kind code 1 (left shift) with amount n from 1 to 31 gives the source moved n places toward the MSB with zeros entering at the bottom. The carry is source bit 32-n.
- R4: Kind code 2 (logical right shift) with n from 1 to 31 gives the source moved n places toward the LSB with zeros entering at the top. The carry is source bit n-1.
- R5: Kind code 3 (arithmetic right shift) with n from 1 to 31 behaves like code 2, except that copies of the original bit 31 fill the vacated top positions.
- R6: Kind code 4 (rotate right) with a nonzero amount rotates by n modulo 32, and bits leaving bit 0 re-enter at bit 31. The carry is result bit 31. A nonzero multiple of 32 leaves the value unchanged, with carry equal to source bit 31.
- R7: Kind code 5 (rotate right through carry) always rotates by exactly one place and ignores the amount. `carry_i` enters bit 31, and the carry is source bit 0.
- R8: For codes 1 to 4, an amount of zero yields the source unchanged and copies `carry_i` to `carry_o`.
- R9: When `amt_is_reg_i` is 1 the amount is `amt_reg_i[7:0]` only, and bits 31:8 have no effect. Otherwise the amount is `amt_imm_i`.
- R10: For amounts of 32 or more, codes 1 and 2 give zero, and code 3 gives 32 copies of bit 31 with carry equal to bit 31. At exactly 32 the carry of code 1 is source bit 0 and that of code 2 is source bit 31. Above 32 both give carry 0.
- R11: With `OUT_REG`=1 the outputs appear one clock after the inputs and are zero during reset. With `OUT_REG`=0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| kind_i | input | 3 | Operation code: 0 pass, 1 left, 2 logical right, 3 arithmetic right, 4 rotate, 5 rotate through carry |
| src_is_imm_i | input | 1 | Selects the immediate as the source value |
| val_reg_i | input | 32 | Register source value |
| val_imm_i | input | 32 | Immediate source value |
| amt_is_reg_i | input | 1 | Selects the register amount |
| amt_imm_i | input | 5 | Immediate shift amount |
| amt_reg_i | input | 32 | Register holding the shift amount (low byte used) |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Generated operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds two copies at the default 32-bit width and 8-bit register amount width. One copy has `OUT_REG`=1 and the other has `OUT_REG`=0, so both the same-cycle path and the registered path are compared against one reference on every vector. The full 8-bit amount range is within reach, so amounts of exactly 32, just above 32, 255 and multiples of 32 under rotation are driven directly. Register amounts with noise in their upper 24 bits show that those bits have no effect.

// File: rtl/shop_pkg.sv
package shop_pkg;

    typedef enum logic [2:0] {
        SK_PASS = 3'd0,
        SK_LSL  = 3'd1,
        SK_LSR  = 3'd2,
        SK_ASR  = 3'd3,
        SK_ROR  = 3'd4,
        SK_RRX  = 3'd5
    } shift_kind_e;

endpackage

// File: rtl/shop_amount.sv
module shop_amount #(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8
) (
    input  logic                 amt_is_reg,
    input  logic [IMM_AMT_W-1:0] amt_imm,
    input  logic [DATA_W-1:0]    amt_reg,
    output logic [REG_AMT_W-1:0] amt
);
    logic hi_unused;
    assign hi_unused = ^amt_reg[DATA_W-1:REG_AMT_W];

    always_comb begin
        if (amt_is_reg) begin
            amt = amt_reg[REG_AMT_W-1:0];
        end else begin
            amt = REG_AMT_W'(amt_imm);
        end
    end
endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
    import shop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [2:0]        kind,
    input  logic [DATA_W-1:0] val,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int LG = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(DATA_W);
    localparam logic [LG:0]      W_LG  = (LG+1)'(DATA_W);

    logic [LG-1:0]        sh;
    logic [LG:0]          rsh;
    logic                 big, exact, zero, msb;
    logic [DATA_W:0]      lsl_x;
    logic [DATA_W:0]      lsr_x;
    logic signed [DATA_W:0] asr_x;
    logic [DATA_W-1:0]    ror_v;
    shift_kind_e          k;

    assign sh    = amt[LG-1:0];
    assign rsh   = W_LG - {1'b0, sh};
    assign big   = (amt >= W_AMT);
    assign exact = (amt == W_AMT);
    assign zero  = (amt == '0);
    assign msb   = val[DATA_W-1];
    assign lsl_x = {1'b0, val} << sh;
    assign lsr_x = {val, 1'b0} >> sh;
    assign asr_x = $signed({val, 1'b0}) >>> sh;
    assign ror_v = (val >> sh) | (val << rsh);

    always_comb begin
        k    = shift_kind_e'(kind);
        res  = val;
        cout = cin;
        unique case (k)
            SK_LSL: begin
                if (big) begin
                    res  = '0;
                    cout = exact ? val[0] : 1'b0;
                end else if (!zero) begin
                    res  = lsl_x[DATA_W-1:0];
                    cout = lsl_x[DATA_W];
                end
            end
            SK_LSR: begin
                if (big) begin
                    res  = '0;
                    cout = exact ? msb : 1'b0;
                end else if (!zero) begin
                    res  = lsr_x[DATA_W:1];
                    cout = lsr_x[0];
                end
            end
            SK_ASR: begin
                if (big) begin
                    res  = {DATA_W{msb}};
                    cout = msb;
                end else if (!zero) begin
                    res  = asr_x[DATA_W:1];
                    cout = asr_x[0];
                end
            end
            SK_ROR: begin
                if (!zero) begin
                    res  = ror_v;
                    cout = ror_v[DATA_W-1];
                end
            end
            SK_RRX: begin
                res  = {cin, val[DATA_W-1:1]};
                cout = val[0];
            end
            default: begin
                res  = val;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/opgen_shifter.sv
module opgen_shifter
    import shop_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8,
    parameter bit OUT_REG   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           kind_i,
    input  logic                 src_is_imm_i,
    input  logic [DATA_W-1:0]    val_reg_i,
    input  logic [DATA_W-1:0]    val_imm_i,
    input  logic                 amt_is_reg_i,
    input  logic [IMM_AMT_W-1:0] amt_imm_i,
    input  logic [DATA_W-1:0]    amt_reg_i,
    input  logic                 carry_i,
    output logic [DATA_W-1:0]    operand_o,
    output logic                 carry_o
);
    localparam logic [REG_AMT_W-1:0] W_AMT = REG_AMT_W'(DATA_W);

    logic [DATA_W-1:0]    sel_val;
    logic [REG_AMT_W-1:0] sel_amt;
    logic [DATA_W-1:0]    core_res;
    logic                 core_cout;

    assign sel_val = src_is_imm_i ? val_imm_i : val_reg_i;

    shop_amount #(
        .DATA_W   (DATA_W),
        .IMM_AMT_W(IMM_AMT_W),
        .REG_AMT_W(REG_AMT_W)
    ) u_amount (
        .amt_is_reg(amt_is_reg_i),
        .amt_imm   (amt_imm_i),
        .amt_reg   (amt_reg_i),
        .amt       (sel_amt)
    );

    shop_shift_core #(
        .DATA_W(DATA_W),
        .AMT_W (REG_AMT_W)
    ) u_core (
        .kind(kind_i),
        .val (sel_val),
        .amt (sel_amt),
        .cin (carry_i),
        .res (core_res),
        .cout(core_cout)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    operand_o <= '0;
                    carry_o   <= 1'b0;
                end else begin
                    operand_o <= core_res;
                    carry_o   <= core_cout;
                end
            end

            // R11
            out_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (operand_o == $past(core_res) && carry_o == $past(core_cout)));
        end else begin : g_comb
            assign operand_o = core_res;
            assign carry_o   = core_cout;
        end
    endgenerate

    // R1
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 3'd0 || kind_i == 3'd6 || kind_i == 3'd7)
        |-> (core_res == sel_val && core_cout == carry_i));

    // R7
    rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 3'd5) |-> (core_res[DATA_W-1] == carry_i &&
                              core_res[DATA_W-2:0] == sel_val[DATA_W-1:1] &&
                              core_cout == sel_val[0]));

    // R8
    zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i >= 3'd1 && kind_i <= 3'd4 && sel_amt == '0)
        |-> (core_res == sel_val && core_cout == carry_i));

    // R5
    asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 3'd3) |-> (core_res[DATA_W-1] == sel_val[DATA_W-1]));

    // R10
    big_lsl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 3'd1 && sel_amt > W_AMT) |-> (core_res == '0 && core_cout == 1'b0));
endmodule

// File: tb/opgen_shifter_bench.sv
module opgen_shifter_bench;
    localparam int W = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n;
    logic [2:0]   kind;
    logic         simm;
    logic [W-1:0] vreg, vimm, areg;
    logic         asel;
    logic [4:0]   aimm;
    logic         cin;
    logic [W-1:0] op_q, op_c;
    logic         c_q, c_c;

    opgen_shifter #(.OUT_REG(1'b1)) u_opgen_shifter (
        .clk(clk), .rst_n(rst_n), .kind_i(kind), .src_is_imm_i(simm),
        .val_reg_i(vreg), .val_imm_i(vimm), .amt_is_reg_i(asel),
        .amt_imm_i(aimm), .amt_reg_i(areg), .carry_i(cin),
        .operand_o(op_q), .carry_o(c_q));

    opgen_shifter #(.OUT_REG(1'b0)) u_opgen_shifter_comb (
        .clk(clk), .rst_n(rst_n), .kind_i(kind), .src_is_imm_i(simm),
        .val_reg_i(vreg), .val_imm_i(vimm), .amt_is_reg_i(asel),
        .amt_imm_i(aimm), .amt_reg_i(areg), .carry_i(cin),
        .operand_o(op_c), .carry_o(c_c));

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Behavioural reference: step one place at a time, remembering the last bit out.
    task automatic model(output logic [W-1:0] r, output logic c, output string tag);
        logic [W-1:0] v;
        int n;
        v = simm ? vimm : vreg;
        n = asel ? int'(areg[7:0]) : int'(aimm);
        r = v;
        c = cin;
        tag = simm ? "R2" : "R1";
        if (kind >= 3'd1 && kind <= 3'd4) begin
            for (int i = 0; i < n; i++) begin
                case (kind)
                    3'd1: begin c = r[W-1]; r = {r[W-2:0], 1'b0}; end
                    3'd2: begin c = r[0];   r = {1'b0, r[W-1:1]}; end
                    3'd3: begin c = r[0];   r = {r[W-1], r[W-1:1]}; end
                    default: begin c = r[0]; r = {r[0], r[W-1:1]}; end
                endcase
            end
            case (kind)
                3'd1: tag = "R3";
                3'd2: tag = "R4";
                3'd3: tag = "R5";
                default: tag = "R6";
            endcase
            if (n >= W && kind != 3'd4) tag = "R10";
            if (n == 0) tag = "R8";
            if (asel && areg[W-1:8] != '0) tag = "R9";
        end else if (kind == 3'd5) begin
            r = {cin, v[W-1:1]};
            c = v[0];
            tag = "R7";
        end
    endtask

    task automatic check(input string tag, input logic [W-1:0] got, input logic gc,
                         input logic [W-1:0] exp, input logic ec);
        vectors++;
        if (got !== exp || gc !== ec) begin
            miscompares++;
            $display("FAIL %s: got %h carry %b, expected %h carry %b", tag, got, gc, exp, ec);
        end
    endtask

    task automatic apply(input logic [2:0] k, input logic si, input logic [W-1:0] vr,
                         input logic [W-1:0] vi, input logic as, input logic [4:0] ai,
                         input logic [W-1:0] ar, input logic ci);
        logic [W-1:0] er;
        logic ec;
        string tag;
        @(negedge clk);
        kind = k; simm = si; vreg = vr; vimm = vi; asel = as; aimm = ai; areg = ar; cin = ci;
        #1;
        model(er, ec, tag);
        check(tag, op_c, c_c, er, ec);
        @(posedge clk);
        #1;
        check("R11", op_q, c_q, er, ec);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        kind = 3'd1; simm = 1'b0; vreg = 32'hDEAD_BEEF; vimm = '0;
        asel = 1'b0; aimm = 5'd3; areg = '0; cin = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R11", op_q, c_q, '0, 1'b0);   // R11 reset state
        @(negedge clk);
        rst_n = 1'b1;

        apply(3'd0, 0, 32'h1234_5678, 32'h0, 0, 5'd7, 0, 1);            // R1
        apply(3'd0, 1, 32'h1234_5678, 32'h0000_1234, 0, 5'd7, 0, 0);    // R2
        apply(3'd6, 0, 32'hCAFE_0001, 0, 1, 0, 32'd4, 1);               // R1 unused code
        apply(3'd7, 1, 0, 32'h8000_0000, 0, 5'd9, 0, 0);                // R1 unused code
        apply(3'd1, 0, 32'h8000_000F, 0, 0, 5'd4, 0, 0);                // R3
        apply(3'd1, 0, 32'h8000_0001, 0, 0, 5'd1, 0, 0);                // R3 carry from MSB
        apply(3'd1, 1, 0, 32'h0000_00FF, 0, 5'd31, 0, 1);               // R3 with immediate
        apply(3'd2, 0, 32'hF000_0001, 0, 1, 0, 32'd31, 0);              // R4
        apply(3'd2, 0, 32'h0000_0003, 0, 0, 5'd1, 0, 0);                // R4
        apply(3'd3, 0, 32'h8000_0010, 0, 0, 5'd8, 0, 0);                // R5 negative
        apply(3'd3, 0, 32'h4000_0010, 0, 1, 0, 32'd5, 1);               // R5 positive
        apply(3'd4, 0, 32'h0000_00AB, 0, 0, 5'd8, 0, 0);                // R6
        apply(3'd4, 0, 32'h1234_5678, 0, 1, 0, 32'd36, 0);              // R6 modulo
        apply(3'd4, 0, 32'h8000_0001, 0, 1, 0, 32'd32, 0);              // R6 multiple of 32
        apply(3'd4, 0, 32'h0000_0001, 0, 1, 0, 32'd64, 0);              // R6 multiple of 32
        apply(3'd5, 0, 32'h0000_0003, 0, 0, 5'd9, 0, 1);                // R7 carry in set
        apply(3'd5, 0, 32'hFFFF_FFFE, 0, 1, 0, 32'd17, 0);              // R7 amount ignored
        for (int k = 1; k <= 4; k++)
            apply(3'(k), 0, 32'h9ABC_DEF1, 0, 0, 5'd0, 0, 1'(k & 1));   // R8
        apply(3'd1, 0, 32'h0000_0005, 0, 1, 0, 32'h0000_0100, 0);       // R9 low byte zero
        apply(3'd2, 0, 32'h8000_0000, 0, 1, 0, 32'hFFFF_FF05, 1);       // R9 upper noise
        apply(3'd1, 0, 32'h0000_0001, 0, 1, 0, 32'd32, 0);              // R10 exact
        apply(3'd1, 0, 32'hFFFF_FFFF, 0, 1, 0, 32'd33, 1);              // R10 above
        apply(3'd2, 0, 32'h8000_0000, 0, 1, 0, 32'd32, 0);              // R10 exact
        apply(3'd2, 0, 32'hFFFF_FFFF, 0, 1, 0, 32'd200, 1);             // R10 above
        apply(3'd3, 0, 32'h8000_0000, 0, 1, 0, 32'd40, 0);              // R10 negative
        apply(3'd3, 0, 32'h7FFF_FFFF, 0, 1, 0, 32'd255, 1);             // R10 positive

        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] ar;
            ar = $urandom();
            if (i % 3 != 0) ar[7:0] = 8'($urandom_range(0, 40));
            apply(3'($urandom_range(0, 7)), 1'($urandom()), $urandom(), $urandom(),
                  1'($urandom()), 5'($urandom()), ar, 1'($urandom()));
        end

        summary();
    end
endmodule